// File: doc/BRIEF.md
# Interrupt Controller Command Front End

This block is the register front end of one programmable interrupt controller for eight inputs. It sits on an 8-bit I/O bus with two ports, a control port and a data port. A control-port write with bit 4 set opens a setup sequence. The data-port writes that follow are routed by their position in that sequence: first the vector base, then the cascade word, then the mode word. Once the sequence completes, data-port writes load the interrupt mask.

The block presents the values it has captured to the downstream priority logic, together with a flag that shows the setup is complete. It also keeps the in-service register. The priority logic sets bits in that register through a pulse vector, and software clears them with a non-specific end-of-interrupt command written to the control port.

Top module: `pic_cmd_front`

## Requirements
- R1: After reset, init_done_o is 0, mask_o is 0xFF, isr_o is 0, and vec_base_o, cascade_o and mode_o are 0.
- R2: A control-port write with bit 4 set (setup word) does the following in the next cycle: it clears mask_o to 0x00, mode_o to 0 and cascade_o to 0, drops init_done_o, latches single_o from bit 1, and makes the next data write the vector base.
- R3: The stored vector base takes bits 7:3 of the written value, and its bits 2:0 always read 0.
- R4: In cascade mode (setup bit 1 = 0), the data write after the base loads cascade_o. If setup bit 0 = 1, the write after that loads mode_o, and init_done_o then rises.
- R5: In single mode (setup bit 1 = 1), the cascade step is skipped and cascade_o stays 0.
- R6: With setup bit 0 = 0, the mode step is skipped, mode_o stays 0, and init_done_o rises after the last preceding step.
- R7: A setup word written in the middle of a sequence restarts the sequence at the vector base step.
- R8: Once init_done_o is 1, a data-port write loads mask_o without changing the base, cascade or mode values. A data-port read (rd_i with sel_data_i = 1) returns the mask on rdata_o in the same cycle, and rdata_o is 0 otherwise.
- R9: Before the first setup sequence completes, data-port writes leave the mask unchanged.
- R10: A control write with bits 7:5 = 001 and bits 4:3 = 00 (non-specific end of interrupt), made while init_done_o is 1, clears the lowest-numbered set bit of isr_o. Input 0 has the highest priority, and only one bit is cleared.
- R11: Each bit of isr_set_i sets the matching isr_o bit, which stays set until an end of interrupt clears it. Other control-port command codes, and end-of-interrupt commands issued before setup completes, leave isr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| sel_data_i | input | 1 | Port select: 1 = data port, 0 = control port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (mask on a data-port read, else 0) |
| isr_set_i | input | 8 | Pulses from priority logic that set in-service bits |
| vec_base_o | output | 8 | Vector base, low 3 bits zero |
| cascade_o | output | 8 | Cascade word |
| mode_o | output | 8 | Mode word |
| mask_o | output | 8 | Interrupt mask, 1 disables an input |
| isr_o | output | 8 | In-service register |
| single_o | output | 1 | Single-controller mode latched at setup |
| init_done_o | output | 1 | Setup sequence complete |

## Verification
The setup sequence is driven with four setup words: full cascade with a mode word, single mode with a mode word, cascade without a mode word, and a sequence restarted midway. These show whether each data write lands in the right register for its position, and whether the skipped steps keep their cleared defaults. A base value with nonzero low bits shows whether those bits are dropped. The in-service register is preloaded with several bits and then hit with a specific-form command and repeated non-specific commands. This separates lowest-bit-first clearing from other clear orders, and separates a single-bit clear from wider ones.

// File: rtl/pic_front_pkg.sv
package pic_front_pkg;
  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_READY
  } seq_st_e;

  localparam int unsigned SETUP_BIT  = 4;
  localparam int unsigned OCW3_BIT   = 3;
  localparam logic [2:0]  EOI_NS_CODE = 3'b001;
endpackage

// File: rtl/pic_icw_seq.sv
module pic_icw_seq
  import pic_front_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BASE_LSB = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_wr_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] vec_base_o,
  output logic [DATA_W-1:0] cascade_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              single_o,
  output logic              init_done_o
);
  seq_st_e st_q, st_d;
  logic    need_mode_q;

  always_comb begin
    st_d = st_q;
    if (setup_wr_i) begin
      st_d = ST_BASE;
    end else if (data_wr_i) begin
      unique case (st_q)
        ST_BASE: st_d = !single_o ? ST_CASC : (need_mode_q ? ST_MODE : ST_READY);
        ST_CASC: st_d = need_mode_q ? ST_MODE : ST_READY;
        ST_MODE: st_d = ST_READY;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_UNINIT;
      need_mode_q <= 1'b0;
      single_o    <= 1'b0;
      vec_base_o  <= '0;
      cascade_o   <= '0;
      mode_o      <= '0;
      mask_o      <= '1;
    end else begin
      st_q <= st_d;
      if (setup_wr_i) begin
        need_mode_q <= wdata_i[0];
        single_o    <= wdata_i[1];
        cascade_o   <= '0;
        mode_o      <= '0;
        mask_o      <= '0;
      end else if (data_wr_i) begin
        unique case (st_q)
          ST_BASE:  vec_base_o <= {wdata_i[DATA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
          ST_CASC:  cascade_o  <= wdata_i;
          ST_MODE:  mode_o     <= wdata_i;
          ST_READY: mask_o     <= wdata_i;
          default:  ;
        endcase
      end
    end
  end

  assign init_done_o = (st_q == ST_READY);

  // R2
  setup_clears_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_wr_i |=> (mask_o == '0) && !init_done_o);
  // R8
  mask_wr_keeps_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_o && data_wr_i && !setup_wr_i) |=> $stable(vec_base_o) && $stable(mode_o));
  // R9
  pre_init_mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UNINIT && !setup_wr_i) |=> $stable(mask_o));
  // R5
  single_no_casc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_o && !setup_wr_i) |=> $stable(cascade_o));
endmodule

// File: rtl/pic_isr_eoi.sv
module pic_isr_eoi #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               eoi_i,
  input  logic [NUM_IRQ-1:0] set_i,
  output logic [NUM_IRQ-1:0] isr_o
);
  localparam logic [NUM_IRQ-1:0] ONE = NUM_IRQ'(1);

  logic [NUM_IRQ-1:0] cleared;

  // Drop lowest set bit: input 0 wins
  assign cleared = eoi_i ? (isr_o & (isr_o - ONE)) : isr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= cleared | set_i;
  end

  // R10
  eoi_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && set_i == '0) |=>
      ($countones(isr_o) + int'(|$past(isr_o)) == $countones($past(isr_o))));
  // R11
  isr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoi_i |=> ((isr_o & $past(isr_o)) == $past(isr_o)));
endmodule

// File: rtl/pic_cmd_front.sv
module pic_cmd_front
  import pic_front_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              sel_data_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] isr_set_i,
  output logic [DATA_W-1:0] vec_base_o,
  output logic [DATA_W-1:0] cascade_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] isr_o,
  output logic              single_o,
  output logic              init_done_o
);
  localparam int unsigned NUM_IRQ  = DATA_W;
  localparam int unsigned BASE_LSB = $clog2(NUM_IRQ);

  logic ctrl_wr, data_wr, setup_wr, eoi_ns;

  assign ctrl_wr  = wr_i && !sel_data_i;
  assign data_wr  = wr_i && sel_data_i;
  assign setup_wr = ctrl_wr && wdata_i[SETUP_BIT];
  assign eoi_ns   = ctrl_wr && init_done_o && !wdata_i[SETUP_BIT] && !wdata_i[OCW3_BIT]
                    && (wdata_i[DATA_W-1:DATA_W-3] == EOI_NS_CODE);

  pic_icw_seq #(.DATA_W(DATA_W), .BASE_LSB(BASE_LSB)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .setup_wr_i (setup_wr),
    .data_wr_i  (data_wr),
    .wdata_i    (wdata_i),
    .vec_base_o (vec_base_o),
    .cascade_o  (cascade_o),
    .mode_o     (mode_o),
    .mask_o     (mask_o),
    .single_o   (single_o),
    .init_done_o(init_done_o)
  );

  pic_isr_eoi #(.NUM_IRQ(NUM_IRQ)) u_isr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .eoi_i (eoi_ns),
    .set_i (isr_set_i),
    .isr_o (isr_o)
  );

  assign rdata_o = (rd_i && sel_data_i) ? mask_o : '0;

  // R11
  eoi_pre_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && isr_set_i == '0) |=> (isr_o == $past(isr_o)));
endmodule

// File: tb/pic_cmd_front_tb.sv
module pic_cmd_front_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [7:0] wdata = '0, isr_set = '0;
  logic [7:0] rdata, base, casc, mode, mask, isr;
  logic       single, done;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pic_cmd_front u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .rd_i(rd), .sel_data_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .isr_set_i(isr_set),
    .vec_base_o(base), .cascade_o(casc), .mode_o(mode), .mask_o(mask),
    .isr_o(isr), .single_o(single), .init_done_o(done)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic port_data, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; sel = port_data; wdata = d;
    @(negedge clk);
    wr = 1'b0; sel = 1'b0; wdata = '0;
  endtask

  task automatic read_mask(output logic [7:0] v);
    @(negedge clk);
    rd = 1'b1; sel = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0; sel = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 done", {7'd0, done}, 8'h00);
    chk("R1 mask", mask, 8'hFF);
    chk("R1 isr", isr, 8'h00);
    chk("R1 base", base, 8'h00);
    chk("R1 mode", mode, 8'h00);
  endtask

  task automatic t_pre_init;
    logic [7:0] v;
    bus_wr(1'b1, 8'h55);
    read_mask(v);
    chk("R9 mask ignored", v, 8'hFF);
    @(negedge clk); isr_set = 8'h01;
    @(negedge clk); isr_set = 8'h00;
    bus_wr(1'b0, 8'h20);
    chk("R11 eoi before init", isr, 8'h01);
  endtask

  task automatic t_cascade;
    bus_wr(1'b0, 8'h11);
    chk("R2 mask cleared", mask, 8'h00);
    chk("R2 not done", {7'd0, done}, 8'h00);
    bus_wr(1'b1, 8'h6D);
    chk("R3 base low bits", base, 8'h68);
    bus_wr(1'b1, 8'h04);
    chk("R4 cascade", casc, 8'h04);
    chk("R4 not yet done", {7'd0, done}, 8'h00);
    bus_wr(1'b1, 8'h01);
    chk("R4 mode", mode, 8'h01);
    chk("R4 done", {7'd0, done}, 8'h01);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    bus_wr(1'b1, 8'hA5);
    read_mask(v);
    chk("R8 mask readback", v, 8'hA5);
    chk("R8 base kept", base, 8'h68);
    chk("R8 mode kept", mode, 8'h01);
    @(negedge clk); rd = 1'b1; sel = 1'b0;
    #1 chk("R8 control read zero", rdata, 8'h00);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_single;
    bus_wr(1'b0, 8'h13);
    chk("R5 single flag", {7'd0, single}, 8'h01);
    bus_wr(1'b1, 8'h20);
    chk("R5 base", base, 8'h20);
    bus_wr(1'b1, 8'h03);
    chk("R5 mode in third write", mode, 8'h03);
    chk("R5 cascade untouched", casc, 8'h00);
    chk("R5 done", {7'd0, done}, 8'h01);
  endtask

  task automatic t_no_mode;
    bus_wr(1'b1, 8'h3C);
    bus_wr(1'b0, 8'h10);
    chk("R2 mask cleared again", mask, 8'h00);
    chk("R2 mode cleared", mode, 8'h00);
    bus_wr(1'b1, 8'h70);
    bus_wr(1'b1, 8'h02);
    chk("R6 cascade", casc, 8'h02);
    chk("R6 done", {7'd0, done}, 8'h01);
    chk("R6 mode zero", mode, 8'h00);
  endtask

  task automatic t_restart;
    bus_wr(1'b0, 8'h11);
    bus_wr(1'b1, 8'h40);
    bus_wr(1'b0, 8'h11);
    bus_wr(1'b1, 8'h50);
    chk("R7 base from restart", base, 8'h50);
    chk("R7 not done", {7'd0, done}, 8'h00);
    bus_wr(1'b1, 8'h04);
    bus_wr(1'b1, 8'h01);
    chk("R7 done", {7'd0, done}, 8'h01);
    chk("R7 cascade", casc, 8'h04);
  endtask

  task automatic t_eoi;
    @(negedge clk); isr_set = 8'h0A;
    @(negedge clk); isr_set = 8'h00;
    chk("R11 isr set", isr, 8'h0B);
    bus_wr(1'b0, 8'h60);
    chk("R11 other code ignored", isr, 8'h0B);
    bus_wr(1'b0, 8'h20);
    chk("R10 eoi 1", isr, 8'h0A);
    bus_wr(1'b0, 8'h20);
    chk("R10 eoi 2", isr, 8'h08);
    bus_wr(1'b0, 8'h20);
    chk("R10 eoi 3", isr, 8'h00);
    bus_wr(1'b0, 8'h20);
    chk("R10 eoi empty", isr, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_pre_init();
    t_cascade();
    t_mask();
    t_single();
    t_no_mode();
    t_restart();
    t_eoi();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule